// File: doc/BRIEF.md
# Squaring Multiply-Accumulate Datapath

This block is the arithmetic core of a fixed-point signal processor. It has two signed operand registers, x and y, each DW bits wide. It has a product register p of 2*DW bits and two accumulators. Each accumulator is 2*DW+GUARD bits wide, and the extra GUARD bits above the product width catch overflow. Every accepted command word can do three things together:

- load y, x or both from the `din` bus;
- multiply the current x by the current y into p;
- run one accumulator operation on the selected accumulator.

The accumulator operation uses the value p held before the edge. One word can therefore retire the previous product while it forms the next one.

A squaring mode bit makes every y load also write the same value into x. With this mode set, a stream of samples can be squared at one result per word. Each word loads a sample, multiplies and moves p into an accumulator. The square of each sample reaches the accumulator two words after the sample was loaded.

Commands arrive on a valid/ready port. The datapath never stalls, so `cmd_ready` is always high. A word takes effect on the rising edge where `cmd_valid` is high. When `cmd_valid` is low nothing changes, and the command fields and `din` are ignored. All results appear on registered outputs one cycle after the word is accepted.

Top module: `mac_sq_dp`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears x, y, p, both accumulators, the N/Z/V flags and the squaring mode bit to zero.
- R2: In an accepted word, `cmd_ld_y` writes `din` into y and `cmd_ld_x` writes `din` into x.
- R3: In an accepted word with `cmd_mul` set, p becomes the signed product of the x and y values held before that edge. This holds even when the same word loads new operands.
- R4: `cmd_mode_wr` writes `cmd_mode_val` into the squaring mode bit, and the new value governs later words. While the bit is 1, any accepted word with `cmd_ld_y` also writes `din` into x.
- R5: Opcode 1 (move) writes the pre-edge p, sign-extended, into the selected accumulator. When move, multiply and y load are combined in squaring mode, the square of each streamed sample reaches the accumulator two words after that sample was loaded.
- R6: Opcodes 2/3/4/5/6 combine the accumulator with sign-extended p by add, subtract, AND, OR and XOR. Opcode 7 adds `din` placed in bits [2*DW-1:DW], with the bits below it zero and the bits above it sign-extended.
- R7: Opcodes 8/9/10/11 shift the selected accumulator by one bit: arithmetic right (copy of the top bit), logical right (zero fill), arithmetic left and logical left (zero into bit 0).
- R8: Opcode 12 replaces the selected accumulator with its one's complement.
- R9: After any opcode from 1 to 13, the flags are updated from the result. N is the top bit and Z means the result is all zeros. V is set on signed overflow for opcodes 2, 3, 7 and 13, and for opcode 10 when the top two bits of the source differ; otherwise V is 0. Opcodes 0, 14 and 15 leave the flags unchanged.
- R10: A word with all fields zero, and any cycle with `cmd_valid` low, leaves every register unchanged.
- R11: `cmd_ready` is always 1, and a word is accepted exactly when `cmd_valid` is 1.
- R12: `cmd_acc` selects accumulator 0 or 1 as the source and destination. Opcode 13 adds the other accumulator to the selected one. Opcodes 0, 14 and 15 write no accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Always 1; the datapath never back-pressures |
| cmd_ld_x | input | 1 | Load x from din |
| cmd_ld_y | input | 1 | Load y from din (and x in squaring mode) |
| cmd_mul | input | 1 | p gets x*y |
| cmd_alu | input | 4 | Accumulator opcode (0 none, 1..13 see R5-R9, R12) |
| cmd_acc | input | 1 | Accumulator select |
| cmd_mode_wr | input | 1 | Write the squaring mode bit |
| cmd_mode_val | input | 1 | New squaring mode value |
| din | input | DW | Data input bus |
| x_q | output | DW | x register |
| y_q | output | DW | y register |
| p_q | output | 2*DW | Product register |
| acc0_q | output | 2*DW+GUARD | Accumulator 0 |
| acc1_q | output | 2*DW+GUARD | Accumulator 1 |
| flg_n | output | 1 | Negative flag |
| flg_z | output | 1 | Zero flag |
| flg_v | output | 1 | Overflow flag |

## Verification
The bench uses the default DW=16 and GUARD=4. At these values a full-scale square, the square of -32768 (2^30), fits in the product register. Five arithmetic left shifts of that value cross the 36-bit sign boundary, so the overflow flag can be reached in a handful of words. Sixteen-bit operands also keep the square of every streamed sample exactly representable in the bench's 64-bit integers. The datapath can therefore be compared against plain integer arithmetic on every clock, through a directed squaring stream and a long pseudo-random command sequence.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_MOVP = 4'd1,
    OP_ADDP = 4'd2,
    OP_SUBP = 4'd3,
    OP_ANDP = 4'd4,
    OP_ORP  = 4'd5,
    OP_XORP = 4'd6,
    OP_ADDH = 4'd7,
    OP_ASR  = 4'd8,
    OP_LSR  = 4'd9,
    OP_ASL  = 4'd10,
    OP_LSL  = 4'd11,
    OP_NOT  = 4'd12,
    OP_ADDA = 4'd13
  } alu_op_e;

  localparam logic [3:0] OP_LAST = 4'd13;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
  } flags_t;

endpackage

// File: rtl/mac_alu.sv
module mac_alu
  import mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 4
) (
  input  logic [3:0]              op,
  input  logic [2*DW+GUARD-1:0]   acc,
  input  logic [2*DW+GUARD-1:0]   other,
  input  logic [2*DW-1:0]         prod,
  input  logic [DW-1:0]           din,
  output logic [2*DW+GUARD-1:0]   res,
  output flags_t                  flg
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GUARD;

  logic [AW-1:0] p_ext;
  logic [AW-1:0] h_ext;
  logic [AW-1:0] addend;
  logic [AW:0]   sum_ext;
  logic [AW:0]   dif_ext;
  alu_op_e       opc;

  assign opc   = alu_op_e'(op);
  assign p_ext = {{GUARD{prod[PW-1]}}, prod};
  assign h_ext = {{GUARD{din[DW-1]}}, din, {DW{1'b0}}};

  always_comb begin
    case (opc)
      OP_ADDH: addend = h_ext;
      OP_ADDA: addend = other;
      default: addend = p_ext;
    endcase
  end

  assign sum_ext = {acc[AW-1], acc} + {addend[AW-1], addend};
  assign dif_ext = {acc[AW-1], acc} - {addend[AW-1], addend};

  always_comb begin
    res   = acc;
    flg.v = 1'b0;
    case (opc)
      OP_MOVP: res = p_ext;
      OP_ADDP, OP_ADDH, OP_ADDA: begin
        res   = sum_ext[AW-1:0];
        flg.v = sum_ext[AW] ^ sum_ext[AW-1];
      end
      OP_SUBP: begin
        res   = dif_ext[AW-1:0];
        flg.v = dif_ext[AW] ^ dif_ext[AW-1];
      end
      OP_ANDP: res = acc & p_ext;
      OP_ORP:  res = acc | p_ext;
      OP_XORP: res = acc ^ p_ext;
      OP_ASR:  res = {acc[AW-1], acc[AW-1:1]};
      OP_LSR:  res = {1'b0, acc[AW-1:1]};
      OP_ASL: begin
        res   = {acc[AW-2:0], 1'b0};
        flg.v = acc[AW-1] ^ acc[AW-2];
      end
      OP_LSL:  res = {acc[AW-2:0], 1'b0};
      OP_NOT:  res = ~acc;
      default: res = acc;
    endcase
    flg.n = res[AW-1];
    flg.z = (res == '0);
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [2*DW-1:0] prod
);
  logic signed [2*DW-1:0] sprod;

  assign sprod = $signed(a) * $signed(b);
  assign prod  = sprod;
endmodule

// File: rtl/mac_opreg.sv
module mac_opreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          ld_x,
  input  logic          ld_y,
  input  logic          mode_wr,
  input  logic          mode_val,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic          mode_q
);
  logic x_we;

  assign x_we = ld_x | (ld_y & mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      mode_q <= 1'b0;
    end else if (fire) begin
      if (ld_y)    y_q    <= din;
      if (x_we)    x_q    <= din;
      if (mode_wr) mode_q <= mode_val;
    end
  end
endmodule

// File: rtl/mac_sq_dp.sv
module mac_sq_dp
  import mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_ld_x,
  input  logic                  cmd_ld_y,
  input  logic                  cmd_mul,
  input  logic [3:0]            cmd_alu,
  input  logic                  cmd_acc,
  input  logic                  cmd_mode_wr,
  input  logic                  cmd_mode_val,
  input  logic [DW-1:0]         din,
  output logic [DW-1:0]         x_q,
  output logic [DW-1:0]         y_q,
  output logic [2*DW-1:0]       p_q,
  output logic [2*DW+GUARD-1:0] acc0_q,
  output logic [2*DW+GUARD-1:0] acc1_q,
  output logic                  flg_n,
  output logic                  flg_z,
  output logic                  flg_v
);
  localparam int PW   = 2 * DW;
  localparam int AW   = PW + GUARD;
  localparam int NACC = 2;

  logic          fire;
  logic          mode_q;
  logic [PW-1:0] prod;
  logic [AW-1:0] acc [NACC];
  logic [AW-1:0] alu_res;
  flags_t        alu_flg;
  flags_t        flg_q;
  logic          alu_we;

  assign cmd_ready = 1'b1;
  assign fire      = cmd_valid & cmd_ready;
  assign alu_we    = fire && (cmd_alu != 4'(OP_NONE)) && (cmd_alu <= OP_LAST);

  mac_opreg #(.DW(DW)) u_opreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .ld_x     (cmd_ld_x),
    .ld_y     (cmd_ld_y),
    .mode_wr  (cmd_mode_wr),
    .mode_val (cmd_mode_val),
    .din      (din),
    .x_q      (x_q),
    .y_q      (y_q),
    .mode_q   (mode_q)
  );

  mac_mult #(.DW(DW)) u_mult (
    .a    (x_q),
    .b    (y_q),
    .prod (prod)
  );

  mac_alu #(.DW(DW), .GUARD(GUARD)) u_alu (
    .op    (cmd_alu),
    .acc   (acc[cmd_acc]),
    .other (acc[~cmd_acc]),
    .prod  (p_q),
    .din   (din),
    .res   (alu_res),
    .flg   (alu_flg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q <= '0;
    end else if (fire && cmd_mul) begin
      p_q <= prod;
    end
  end

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc[g] <= '0;
      end else if (alu_we && (cmd_acc == 1'(g))) begin
        acc[g] <= alu_res;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else if (alu_we) begin
      flg_q <= alu_flg;
    end
  end

  assign acc0_q = acc[0];
  assign acc1_q = acc[1];
  assign flg_n  = flg_q.n;
  assign flg_z  = flg_q.z;
  assign flg_v  = flg_q.v;
endmodule

// File: rtl/mac_sq_dp_chk.sv
module mac_sq_dp_chk #(
  parameter int DW    = 16,
  parameter int GUARD = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic                  cmd_ld_y,
  input logic                  cmd_mul,
  input logic [3:0]            cmd_alu,
  input logic                  cmd_acc,
  input logic [DW-1:0]         din,
  input logic                  mode_q,
  input logic [DW-1:0]         x_q,
  input logic [DW-1:0]         y_q,
  input logic [2*DW-1:0]       p_q,
  input logic [2*DW+GUARD-1:0] acc0_q,
  input logic [2*DW+GUARD-1:0] acc1_q,
  input logic                  flg_n,
  input logic                  flg_z,
  input logic                  flg_v
);
  localparam int PW = 2 * DW;

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_ready); // R11

  AST_LD_Y: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ld_y |=> y_q == $past(din)); // R2

  AST_MUL_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_mul |=> $signed(p_q) == $signed($past(x_q)) * $signed($past(y_q))); // R3

  AST_SQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ld_y && mode_q |=> x_q == y_q); // R4

  AST_MOVE_P: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_alu == 4'd1 && !cmd_acc |=>
      acc0_q == {{GUARD{$past(p_q[PW-1])}}, $past(p_q)}); // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_alu == 4'd0 |=> $stable({flg_n, flg_z, flg_v})); // R9

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_alu == 4'd1 && !cmd_acc |=> flg_z == (acc0_q == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(x_q) && $stable(y_q) && $stable(p_q)
                   && $stable(acc0_q) && $stable(acc1_q)); // R10
endmodule

bind mac_sq_dp mac_sq_dp_chk #(.DW(DW), .GUARD(GUARD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_ld_y  (cmd_ld_y),
  .cmd_mul   (cmd_mul),
  .cmd_alu   (cmd_alu),
  .cmd_acc   (cmd_acc),
  .din       (din),
  .mode_q    (mode_q),
  .x_q       (x_q),
  .y_q       (y_q),
  .p_q       (p_q),
  .acc0_q    (acc0_q),
  .acc1_q    (acc1_q),
  .flg_n     (flg_n),
  .flg_z     (flg_z),
  .flg_v     (flg_v)
);

// File: tb/mac_sq_dp_tb.sv
module mac_sq_dp_tb;
  localparam int DW = 16;
  localparam int GUARD = 4;
  localparam longint AMASK = (64'sd1 <<< 36) - 1;
  localparam longint AMAX  = (64'sd1 <<< 35) - 1;
  localparam longint AMIN  = -(64'sd1 <<< 35);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_ld_x = 1'b0, cmd_ld_y = 1'b0, cmd_mul = 1'b0;
  logic [3:0]  cmd_alu = '0;
  logic        cmd_acc = 1'b0, cmd_mode_wr = 1'b0, cmd_mode_val = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] x_q, y_q;
  logic [31:0] p_q;
  logic [35:0] acc0_q, acc1_q;
  logic        flg_n, flg_z, flg_v;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  longint mx, my, mp, ma0, ma1;
  bit     mn, mz, mv, mmode;

  always #5 clk = ~clk;

  mac_sq_dp #(.DW(DW), .GUARD(GUARD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ld_x(cmd_ld_x), .cmd_ld_y(cmd_ld_y), .cmd_mul(cmd_mul),
    .cmd_alu(cmd_alu), .cmd_acc(cmd_acc), .cmd_mode_wr(cmd_mode_wr),
    .cmd_mode_val(cmd_mode_val), .din(din), .x_q(x_q), .y_q(y_q), .p_q(p_q),
    .acc0_q(acc0_q), .acc1_q(acc1_q), .flg_n(flg_n), .flg_z(flg_z), .flg_v(flg_v)
  );

  function automatic longint wrap36(longint v);
    longint t;
    t = v & AMASK;
    if (t > AMAX) t = t - (AMASK + 1);
    return t;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " x"}, longint'($signed(x_q)), mx);
    check({tag, " y"}, longint'($signed(y_q)), my);
    check({tag, " p"}, longint'($signed(p_q)), mp);
    check({tag, " acc0"}, longint'($signed(acc0_q)), ma0);
    check({tag, " acc1"}, longint'($signed(acc1_q)), ma1);
    check({tag, " flags"}, longint'({flg_n, flg_z, flg_v}), longint'({mn, mz, mv}));
    check({tag, " ready R11"}, longint'(cmd_ready), 1);
  endtask

  task automatic model_reset();
    mx = 0; my = 0; mp = 0; ma0 = 0; ma1 = 0;
    mn = 0; mz = 0; mv = 0; mmode = 0;
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    @(posedge clk);
    #1;
    model_reset();
    compare_all(tag);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One command word: drive at the falling edge, advance the model, compare after the rising edge
  task automatic step(bit v, bit lx, bit ly, bit mu, int op, bit sel,
                      bit mw, bit mval, int d, string tag);
    longint a, o, r, full, dv, nx, ny, np;
    bit wr, vv;
    @(negedge clk);
    cmd_valid = v; cmd_ld_x = lx; cmd_ld_y = ly; cmd_mul = mu;
    cmd_alu = 4'(op); cmd_acc = sel; cmd_mode_wr = mw; cmd_mode_val = mval;
    din = d[15:0];
    dv = longint'($signed(d[15:0]));
    nx = mx; ny = my; np = mp;
    if (v) begin
      a = sel ? ma1 : ma0;
      o = sel ? ma0 : ma1;
      r = a; full = 0; vv = 0; wr = (op >= 1 && op <= 13);
      case (op)
        1:  r = mp;
        2:  begin full = a + mp;          r = wrap36(full); vv = (full > AMAX || full < AMIN); end
        3:  begin full = a - mp;          r = wrap36(full); vv = (full > AMAX || full < AMIN); end
        4:  r = a & mp;
        5:  r = a | mp;
        6:  r = a ^ mp;
        7:  begin full = a + dv * 65536;  r = wrap36(full); vv = (full > AMAX || full < AMIN); end
        8:  r = a >>> 1;
        9:  r = (a & AMASK) >> 1;
        10: begin full = a * 2;           r = wrap36(full); vv = (full > AMAX || full < AMIN); end
        11: r = wrap36(a * 2);
        12: r = ~a;
        13: begin full = a + o;           r = wrap36(full); vv = (full > AMAX || full < AMIN); end
        default: ;
      endcase
      if (mu) np = mx * my;
      if (ly) ny = dv;
      if (lx || (ly && mmode)) nx = dv;
      if (wr) begin
        if (sel) ma1 = r; else ma0 = r;
        mn = (r < 0); mz = (r == 0); mv = vv;
      end
      if (mw) mmode = mval;
      mx = nx; my = ny; mp = np;
    end
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : stimulus
    int tbl [12];
    int lfsr;
    model_reset();
    tbl = '{-32768, 32767, 0, -1, 1, 181, -181, 12345, -23456, 2, -2, 30000};
    repeat (2) @(posedge clk);
    do_reset("R1 reset");

    // R2 / R3: load operands and multiply
    step(1, 1, 0, 0, 0, 0, 0, 0, 5,  "R2 load x");
    step(1, 0, 1, 0, 0, 0, 0, 0, -3, "R2 load y");
    step(1, 1, 1, 1, 0, 0, 0, 0, 7,  "R3 mul uses old x y");
    check("R3 p = 5*-3", longint'($signed(p_q)), -15);
    step(1, 0, 0, 1, 0, 0, 0, 0, 0,  "R3 mul 7*7");
    check("R3 p = 49", longint'($signed(p_q)), 49);

    // R5 / R6 / R12 accumulator operations
    step(1, 0, 0, 0, 1, 0, 0, 0, 0,    "R5 move p to acc0");
    step(1, 0, 0, 0, 2, 1, 0, 0, 0,    "R6 add p acc1");
    step(1, 0, 0, 0, 3, 0, 0, 0, 0,    "R6 sub p acc0");
    check("R6 acc0 zero after sub", longint'($signed(acc0_q)), 0);
    check("R9 Z after zero result", longint'(flg_z), 1);
    step(1, 0, 0, 0, 7, 0, 0, 0, -2,   "R6 add high half");
    check("R6 acc0 = -2<<16", longint'($signed(acc0_q)), -131072);
    step(1, 0, 0, 0, 4, 0, 0, 0, 0,    "R6 and");
    step(1, 0, 0, 0, 5, 1, 0, 0, 0,    "R6 or");
    step(1, 0, 0, 0, 6, 1, 0, 0, 0,    "R6 xor");
    step(1, 0, 0, 0, 13, 0, 0, 0, 0,   "R12 add other acc");
    step(1, 0, 0, 0, 7, 1, 0, 0, 1234, "R12 acc1 select");

    // R7 / R8 shifts and complement on a negative value
    step(1, 0, 0, 0, 7, 0, 0, 0, -77, "R6 prep");
    step(1, 0, 0, 0, 8, 0, 0, 0, 0,   "R7 asr");
    step(1, 0, 0, 0, 9, 0, 0, 0, 0,   "R7 lsr");
    check("R7 lsr clears top bit", longint'(acc0_q[35]), 0);
    step(1, 0, 0, 0, 10, 0, 0, 0, 0,  "R7 asl");
    step(1, 0, 0, 0, 11, 0, 0, 0, 0,  "R7 lsl");
    step(1, 0, 0, 0, 12, 0, 0, 0, 0,  "R8 not");

    // R9: overflow by repeated left shift of 2^30
    step(1, 1, 1, 0, 0, 0, 0, 0, -32768, "R2 load full scale");
    step(1, 0, 0, 1, 0, 0, 0, 0, 0,      "R3 full scale square");
    step(1, 0, 0, 0, 1, 1, 0, 0, 0,      "R5 move 2^30");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 10, 1, 0, 0, 0, "R9 asl chain");
    check("R9 V on asl overflow", longint'(flg_v), 1);
    step(1, 0, 0, 0, 14, 1, 0, 0, 0, "R9 opcode 14 no effect");
    check("R9 V held by opcode 14", longint'(flg_v), 1);

    // R10 / R11: idle cycles and an all-zero word
    step(0, 1, 1, 1, 2, 0, 1, 1, 999, "R10 invalid word ignored");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0,   "R10 nop word");

    // R4 / R5: squaring stream
    step(1, 0, 0, 0, 0, 0, 1, 1, 0, "R4 set mode");
    for (int i = 0; i < 14; i++) begin
      step(1, 0, 1, 1, 1, 0, 0, 0, (i < 12) ? tbl[i] : 0, "R4 stream");
      if (i < 12) check("R4 x mirrors y", longint'($signed(x_q)), longint'(tbl[i]));
      if (i >= 2) check("R5 square two words later", longint'($signed(acc0_q)),
                        longint'(tbl[i-2]) * longint'(tbl[i-2]));
    end
    step(1, 0, 0, 0, 0, 0, 1, 0, 0,  "R4 clear mode");
    step(1, 0, 1, 0, 0, 0, 0, 0, 55, "R4 no mirror when off");
    check("R4 x unchanged when mode off", longint'($signed(x_q)), 0);

    // Pseudo-random command words
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      int w;
      lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04C1_1DB7 : 0);
      w = lfsr;
      step(w[31] | w[30], w[0], w[1], w[2], w[6:3], w[7], w[8] & w[9], w[10],
           w[27:12], "R12 random");
    end

    do_reset("R1 reset after traffic");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule